// File: doc/BRIEF.md
# Ramp-Conversion and Evaluation Sequencer

This block sequences a three-input piecewise-linear evaluator. At rest it shows the previous result on a shared bus. A start request begins a conversion phase. In that phase one 8-bit counter acts as a digital ramp for three single-slope converters running side by side. Each channel's comparator signal freezes the current ramp value into that channel's 8-bit input register. After the full sweep, the same counter is cleared and reused as the step source for the evaluation datapath, which makes sixteen memory reads. The sequencer then returns to rest.

The latch source of each channel register passes through a multiplexer chosen by state. Comparator activity reaches the register only while a conversion is running. In every other state the source is tied to a constant hold. As a result, the counter sweeping again during evaluation, or comparator noise between runs, cannot disturb the captured inputs. The 2-bit status output is the state register itself, and the bus-direction output follows from it.

Top module: `pwl_seq_ctrl`

## Requirements
- R1: During and right after reset the block is at rest: status `ep_o`=1 and `proc_o`=0, `bus_oe_o`=1, `eval_en_o`=0, `ramp_o`=0, and every channel value is 0.
- R2: The status pair {`ep_o`,`proc_o`} is 10 at rest, 00 while converting and 01 while evaluating. The pair 11 never appears.
- R3: A high `start_i` sampled at a rising edge while at rest moves the block to converting at that edge, with `ramp_o`=0 in the first converting cycle.
- R4: Converting lasts exactly 256 cycles. `ramp_o` reads 0,1,...,255 in those cycles. The edge after the cycle showing 255 enters evaluating with the counter cleared to 0.
- R5: While converting, a channel whose `cmp_hit_i` bit (bit k is channel k) is high at a rising edge, for the first time in the run, captures that cycle's `ramp_o`. The three channels work independently and at the same time. Channel k appears on `chan_val_o[8k+7:8k]`.
- R6: Once a channel has captured in a run, further comparator activity in that run (pulses, chatter, a held level) leaves its value unchanged.
- R7: A channel whose comparator never fires during the sweep holds 255 at the end of the conversion.
- R8: Evaluating lasts exactly 16 cycles, with `eval_en_o`=1 and `step_o` counting 0..15. The edge after step 15 returns the block to rest.
- R9: Outside converting, `cmp_hit_i` has no effect: channel values stay as captured through evaluating and rest.
- R10: `bus_oe_o` is 1 only at rest (the bus drives the result out). It is 0 while converting and evaluating (during evaluation the bus carries memory data in). `eval_en_o` is 1 only while evaluating.
- R11: `start_i` is ignored while converting or evaluating. If it is still high on return to rest, a new conversion starts after a single rest cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only at rest |
| cmp_hit_i | input | 3 | Per-channel comparator signal, bit k for channel k |
| ep_o | output | 1 | Status: at rest / result valid |
| proc_o | output | 1 | Status: evaluating |
| bus_oe_o | output | 1 | 1 = shared bus drives result out, 0 = bus is input |
| eval_en_o | output | 1 | Enables the evaluation datapath |
| step_o | output | 4 | Evaluation step index |
| ramp_o | output | 8 | Shared counter, digital ramp during conversion |
| chan_val_o | output | 24 | Captured channel values, channel k at [8k+7:8k] |

## Verification
The assertions assume that `start_i` and `cmp_hit_i` are synchronous levels that are stable around each rising edge. They also assume that reset is applied before any status check matters. They do not assume that comparators behave monotonically, so the capture bound holds whether a comparator pulses or chatters. The stimulus changes inputs only on falling edges. It derives each comparator bit from the `ramp_o` value already visible in that cycle, using level, single-pulse and chattering models. It also drives comparator bits and `start_i` deliberately during evaluation and rest, where they must be ignored.

// File: rtl/pwl_seq_pkg.sv
package pwl_seq_pkg;

    // State bits double as status: bit 1 = rest/result valid, bit 0 = evaluating
    typedef enum logic [1:0] {
        ST_CONV = 2'b00,
        ST_PROC = 2'b01,
        ST_IDLE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/pwl_seq_fsm.sv
module pwl_seq_fsm
    import pwl_seq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int EVAL_STEPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             arm_o
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(EVAL_STEPS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_reg_t;

    fsm_reg_t r_d, r_q;
    logic     arm_d;

    always_comb begin
        r_d   = r_q;
        arm_d = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (start_i) begin
                    r_d.st = ST_CONV;
                    arm_d  = 1'b1;
                end
            end
            ST_CONV: begin
                if (r_q.cnt == CNT_MAX) begin
                    r_d.st  = ST_PROC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_ONE;
                end
            end
            ST_PROC: begin
                if (r_q.cnt == STEP_LAST) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_ONE;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign cnt_o   = r_q.cnt;
    assign arm_o   = arm_d;

endmodule

// File: rtl/pwl_seq_chan.sv
module pwl_seq_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             conv_i,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] ramp_i,
    output logic [CNT_W-1:0] val_o
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] val;
    } chan_reg_t;

    chan_reg_t r_d, r_q;
    logic      track;

    // State-selected latch source: live only during conversion, constant hold otherwise
    always_comb begin
        if (conv_i) track = r_q.armed;
        else        track = 1'b0;
    end

    always_comb begin
        r_d = r_q;
        if (arm_i) begin
            r_d.armed = 1'b1;
        end else if (track) begin
            r_d.val = ramp_i;
            if (hit_i) r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.armed <= 1'b0;
            r_q.val   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign val_o = r_q.val;

endmodule

// File: rtl/pwl_seq_status.sv
module pwl_seq_status
    import pwl_seq_pkg::*;
(
    input  seq_state_e state_i,
    output logic       ep_o,
    output logic       proc_o,
    output logic       bus_oe_o,
    output logic       eval_en_o,
    output logic       conv_o
);

    always_comb begin
        ep_o      = 1'b0;
        proc_o    = 1'b0;
        bus_oe_o  = 1'b0;
        eval_en_o = 1'b0;
        conv_o    = 1'b0;
        unique case (state_i)
            ST_IDLE: begin
                ep_o     = 1'b1;
                bus_oe_o = 1'b1;
            end
            ST_CONV: conv_o = 1'b1;
            ST_PROC: begin
                proc_o    = 1'b1;
                eval_en_o = 1'b1;
            end
            default: ep_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwl_seq_ctrl.sv
module pwl_seq_ctrl
    import pwl_seq_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int CNT_W      = 8,
    parameter int EVAL_STEPS = 16,
    localparam int STEP_W    = $clog2(EVAL_STEPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NUM_CH-1:0]       cmp_hit_i,
    output logic                    ep_o,
    output logic                    proc_o,
    output logic                    bus_oe_o,
    output logic                    eval_en_o,
    output logic [STEP_W-1:0]       step_o,
    output logic [CNT_W-1:0]        ramp_o,
    output logic [NUM_CH*CNT_W-1:0] chan_val_o
);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             arm;
    logic             conv;

    pwl_seq_fsm #(
        .CNT_W      (CNT_W),
        .EVAL_STEPS (EVAL_STEPS)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_o (state),
        .cnt_o   (cnt),
        .arm_o   (arm)
    );

    pwl_seq_status status_i (
        .state_i   (state),
        .ep_o      (ep_o),
        .proc_o    (proc_o),
        .bus_oe_o  (bus_oe_o),
        .eval_en_o (eval_en_o),
        .conv_o    (conv)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        pwl_seq_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (arm),
            .conv_i (conv),
            .hit_i  (cmp_hit_i[k]),
            .ramp_i (cnt),
            .val_o  (chan_val_o[k*CNT_W +: CNT_W])
        );
    end

    assign ramp_o = cnt;
    assign step_o = cnt[STEP_W-1:0];

endmodule

// File: rtl/pwl_seq_ctrl_chk.sv
module pwl_seq_ctrl_chk #(
    parameter int NUM_CH     = 3,
    parameter int CNT_W      = 8,
    parameter int EVAL_STEPS = 16,
    localparam int STEP_W    = $clog2(EVAL_STEPS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    ep_o,
    input logic                    proc_o,
    input logic                    bus_oe_o,
    input logic                    eval_en_o,
    input logic [STEP_W-1:0]       step_o,
    input logic [CNT_W-1:0]        ramp_o,
    input logic [NUM_CH*CNT_W-1:0] chan_val_o
);

    localparam logic [CNT_W-1:0]  RAMP_MAX  = '1;
    localparam logic [CNT_W-1:0]  RAMP_ONE  = CNT_W'(1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(EVAL_STEPS - 1);

    logic conv;
    assign conv = !ep_o && !proc_o;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ep_o && proc_o)); // R2

    AST_START_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_o && start_i) |=> (conv && ramp_o == '0)); // R3

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && ramp_o != RAMP_MAX) |=> (conv && ramp_o == $past(ramp_o) + RAMP_ONE)); // R4

    AST_CONV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && ramp_o == RAMP_MAX) |=> (proc_o && ramp_o == '0)); // R4

    AST_PROC_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_o && step_o != STEP_LAST) |=> (proc_o && step_o == $past(step_o) + STEP_W'(1))); // R8

    AST_PROC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_o && step_o == STEP_LAST) |=> ep_o); // R8

    AST_FROZEN_OUTSIDE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        !conv |=> $stable(chan_val_o)); // R9

    AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == ep_o) && (eval_en_o == proc_o)); // R10

    for (genvar k = 0; k < NUM_CH; k++) begin : g_bound
        AST_CAPTURE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            conv |=> (chan_val_o[k*CNT_W +: CNT_W] <= $past(ramp_o))); // R5
    end

endmodule

bind pwl_seq_ctrl pwl_seq_ctrl_chk #(
    .NUM_CH     (NUM_CH),
    .CNT_W      (CNT_W),
    .EVAL_STEPS (EVAL_STEPS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ep_o       (ep_o),
    .proc_o     (proc_o),
    .bus_oe_o   (bus_oe_o),
    .eval_en_o  (eval_en_o),
    .step_o     (step_o),
    .ramp_o     (ramp_o),
    .chan_val_o (chan_val_o)
);

// File: tb/pwl_seq_ctrl_tb_top.sv
module pwl_seq_ctrl_tb_top;

    localparam int NUM_CH = 3;
    localparam int CNT_W  = 8;
    localparam int STEPS  = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [NUM_CH-1:0]       cmp_hit_i = '0;
    logic                    ep_o, proc_o, bus_oe_o, eval_en_o;
    logic [3:0]              step_o;
    logic [CNT_W-1:0]        ramp_o;
    logic [NUM_CH*CNT_W-1:0] chan_val_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwl_seq_ctrl #(
        .NUM_CH     (NUM_CH),
        .CNT_W      (CNT_W),
        .EVAL_STEPS (STEPS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_hit_i  (cmp_hit_i),
        .ep_o       (ep_o),
        .proc_o     (proc_o),
        .bus_oe_o   (bus_oe_o),
        .eval_en_o  (eval_en_o),
        .step_o     (step_o),
        .ramp_o     (ramp_o),
        .chan_val_o (chan_val_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int chan(input int k);
        return int'(chan_val_o[k*CNT_W +: CNT_W]);
    endfunction

    // Comparator models: 0 level, 1 single pulse, 2 chatter after first fire
    function automatic bit hit_model(input int mode, input int t, input int r);
        case (mode)
            0:       return r >= t;
            1:       return r == t;
            default: return (r >= t) && (((r - t) % 3) != 1);
        endcase
    endfunction

    task automatic run_conv(input int t0, input int t1, input int t2,
                            input int mode, input bit hold_start);
        int thr[3];
        int expv[3];
        int bad;
        thr[0] = t0; thr[1] = t1; thr[2] = t2;
        for (int k = 0; k < 3; k++) expv[k] = (thr[k] > 255) ? 255 : thr[k];

        chk(ep_o && !proc_o && bus_oe_o && !eval_en_o, "R10 rest status", {ep_o, proc_o}, 2);
        start_i   = 1'b1;
        cmp_hit_i = '0;
        @(negedge clk);
        chk(!ep_o && !proc_o && ramp_o == 0 && !bus_oe_o, "R3 start to converting",
            int'(ramp_o), 0);
        if (!hold_start) start_i = 1'b0;

        bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (!(!ep_o && !proc_o && int'(ramp_o) == i && !bus_oe_o && !eval_en_o)) bad++;
            for (int k = 0; k < 3; k++) cmp_hit_i[k] = hit_model(mode, thr[k], i);
            @(negedge clk);
        end
        chk(bad == 0, "R4 ramp sweep and R2 status", bad, 0);
        chk(proc_o && !ep_o && ramp_o == 0, "R4 enter evaluating", {ep_o, proc_o}, 1);

        for (int k = 0; k < 3; k++) begin
            if (thr[k] > 255)
                chk(chan(k) == expv[k], "R7 no fire gives 255", chan(k), expv[k]);
            else if (mode == 2)
                chk(chan(k) == expv[k], "R6 chatter ignored", chan(k), expv[k]);
            else
                chk(chan(k) == expv[k], "R5 capture", chan(k), expv[k]);
        end

        bad = 0;
        for (int j = 0; j < STEPS; j++) begin
            if (!(proc_o && !ep_o && int'(step_o) == j && eval_en_o && !bus_oe_o)) bad++;
            cmp_hit_i = 3'(j);
            @(negedge clk);
        end
        chk(bad == 0, "R8 evaluation steps and R11 start ignored", bad, 0);
        chk(ep_o && !proc_o && bus_oe_o && !eval_en_o, "R8 return to rest", {ep_o, proc_o}, 2);
        for (int k = 0; k < 3; k++)
            chk(chan(k) == expv[k], "R9 frozen through evaluation", chan(k), expv[k]);

        cmp_hit_i = '1;
        if (hold_start) begin
            @(negedge clk);
            chk(!ep_o && !proc_o && ramp_o == 0, "R11 restart after one rest cycle",
                {ep_o, proc_o}, 0);
            start_i = 1'b0;
            for (int w = 0; w < 400 && !ep_o; w++) @(negedge clk);
            for (int k = 0; k < 3; k++)
                chk(chan(k) == 0, "R5 hit held from start captures 0", chan(k), 0);
        end else begin
            @(negedge clk);
            for (int k = 0; k < 3; k++)
                chk(chan(k) == expv[k], "R9 hits at rest ignored", chan(k), expv[k]);
        end
        cmp_hit_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ep_o && !proc_o && bus_oe_o && !eval_en_o && ramp_o == 0 && chan_val_o == '0,
            "R1 in reset", int'(chan_val_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ep_o && !proc_o && ramp_o == 0 && chan_val_o == '0, "R1 after reset",
            {ep_o, proc_o}, 2);
        // start low at rest: stays at rest
        @(negedge clk);
        chk(ep_o && !proc_o, "R2 rest holds without start", {ep_o, proc_o}, 2);

        for (int t = 0; t < 258; t++) begin
            run_conv(t, (t * 37 + 11) % 258, 257 - t, t % 3, (t % 50) == 7);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule